// File: doc/BRIEF.md
# Multi-Width Subtractor with Status Flags

This block subtracts a source operand from a destination operand and returns the difference at one of four operand widths: 8, 16, 32 or 64 bits. With the difference it produces the six arithmetic status flags: signed overflow, sign, zero, nibble borrow, low-byte parity and unsigned borrow. The same difference is read both as a signed and as an unsigned number, and every flag follows the selected width. A fixed word size is never assumed.

The execution stage presents two 64-bit operands, a two-bit width code and a one-cycle strobe. One clock later the block presents the zero-extended difference, the flags and an output-valid pulse. The operands arrive already sign-extended where the instruction needs it.

A two-state controller handles sequencing. `ST_IDLE` holds while no strobe is seen. A strobe takes the controller to `ST_EMIT` (transition "capture"). Further strobes keep it in `ST_EMIT` (transition "stream"). A cycle without a strobe returns it to `ST_IDLE` (transition "drain"). Reset forces `ST_IDLE`.

Top module: `msub_flagunit`

## Requirements
- R1: When `out_valid` is high, `result_o` equals `dest_i - src_i` from the strobe cycle, truncated to the selected width. All bits above that width are zero.
- R2: The width code `size_sel` means 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits.
- R3: `cf_o` is 1 exactly when the unsigned value of the destination, taken at the selected width, is less than the unsigned value of the source at that width.
- R4: `of_o` is 1 exactly when the operands' top bits at the selected width differ and the result's top bit differs from the destination's top bit.
- R5: `sf_o` equals bit (width-1) of the result.
- R6: `zf_o` is 1 exactly when the result bits within the selected width are all zero. Operand bits above the width have no effect on it.
- R7: `af_o` is 1 exactly when bits [3:0] of the destination, read as an unsigned number, are less than bits [3:0] of the source.
- R8: `pf_o` is 1 exactly when bits [7:0] of the result hold an even number of ones, at every width. Higher result bytes do not affect it.
- R9: `out_valid` is high in the cycle after each cycle in which `in_valid` is sampled high, and low otherwise. Result and flags update with the same one-cycle latency.
- R10: When `in_valid` is low, `result_o` and all flags hold their previous values, whatever the operand and width inputs do.
- R11: After reset, `out_valid`, `result_o` and all six flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| size_sel | input | 2 | Width code (R2) |
| dest_i | input | 64 | Minuend |
| src_i | input | 64 | Subtrahend |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | 64 | Difference, zero-extended |
| of_o | output | 1 | Signed overflow |
| sf_o | output | 1 | Sign |
| zf_o | output | 1 | Zero |
| af_o | output | 1 | Borrow out of bit 3 |
| pf_o | output | 1 | Even parity of the low result byte |
| cf_o | output | 1 | Unsigned borrow |

## Verification
The checker assumes that `size_sel`, `dest_i` and `src_i` are known, non-X values whenever `in_valid` is high. It also assumes that reset is released away from a strobe, because its properties compare outputs with the inputs sampled one cycle earlier. The bench drives every input at the falling edge from a defined value and holds reset across several clean edges before the first strobe. It keeps `in_valid` high only for cycles that carry a complete, deliberate operand set, so every past sample the checker reads is well defined.

// File: rtl/msub_pkg.sv
package msub_pkg;

    localparam int DATA_W    = 64;
    localparam int BYTE_W    = 8;
    localparam int NUM_SIZES = 4;
    localparam int SIZE_W    = $clog2(NUM_SIZES);
    localparam int NIB_W     = 4;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/msub_lane.sv
// One fixed-width subtract lane: difference, unsigned borrow, signed overflow, sign.
module msub_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    output logic [LANE_W-1:0] diff_o,
    output logic              borrow_o,
    output logic              ovf_o,
    output logic              sign_o
);

    logic [LANE_W:0] wide_diff;

    always_comb begin
        wide_diff = {1'b0, a_i} - {1'b0, b_i};
        diff_o    = wide_diff[LANE_W-1:0];
        borrow_o  = wide_diff[LANE_W];
        sign_o    = wide_diff[LANE_W-1];
        ovf_o     = (a_i[LANE_W-1] ^ b_i[LANE_W-1]) &
                    (wide_diff[LANE_W-1] ^ a_i[LANE_W-1]);
    end

endmodule

// File: rtl/msub_core.sv
// Builds one lane per width and selects the lane chosen by the width code.
module msub_core
    import msub_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int LANES = NUM_SIZES,
    parameter int BASE  = BYTE_W
) (
    input  logic [W-1:0]      dest_i,
    input  logic [W-1:0]      src_i,
    input  size_e             size_i,
    output logic [W-1:0]      result_o,
    output logic              borrow_o,
    output logic              ovf_o,
    output logic              sign_o
);

    logic [W-1:0] lane_res [LANES];
    logic [LANES-1:0] lane_borrow;
    logic [LANES-1:0] lane_ovf;
    logic [LANES-1:0] lane_sign;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = BASE << g;
        logic [LW-1:0] diff;

        msub_lane #(.LANE_W(LW)) lane_i (
            .a_i      (dest_i[LW-1:0]),
            .b_i      (src_i[LW-1:0]),
            .diff_o   (diff),
            .borrow_o (lane_borrow[g]),
            .ovf_o    (lane_ovf[g]),
            .sign_o   (lane_sign[g])
        );

        assign lane_res[g] = W'(diff);
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE:  begin result_o = lane_res[0]; borrow_o = lane_borrow[0]; ovf_o = lane_ovf[0]; sign_o = lane_sign[0]; end
            SZ_HALF:  begin result_o = lane_res[1]; borrow_o = lane_borrow[1]; ovf_o = lane_ovf[1]; sign_o = lane_sign[1]; end
            SZ_WORD:  begin result_o = lane_res[2]; borrow_o = lane_borrow[2]; ovf_o = lane_ovf[2]; sign_o = lane_sign[2]; end
            SZ_DWORD: begin result_o = lane_res[3]; borrow_o = lane_borrow[3]; ovf_o = lane_ovf[3]; sign_o = lane_sign[3]; end
            default:  begin result_o = '0; borrow_o = 1'b0; ovf_o = 1'b0; sign_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/msub_flaggen.sv
// Width-independent flags: zero, nibble borrow and low-byte parity.
module msub_flaggen
    import msub_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      result_i,
    input  logic [NIB_W-1:0]  dest_nib_i,
    input  logic [NIB_W-1:0]  src_nib_i,
    output logic              zf_o,
    output logic              af_o,
    output logic              pf_o
);

    // The result is already zero above the selected width, so a full-width test is exact.
    assign zf_o = (result_i == '0);
    assign af_o = (dest_nib_i < src_nib_i);
    assign pf_o = ~(^result_i[BYTE_W-1:0]);

endmodule

// File: rtl/msub_flagunit.sv
module msub_flagunit
    import msub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SIZE_W-1:0]    size_sel,
    input  logic [DATA_W-1:0]    dest_i,
    input  logic [DATA_W-1:0]    src_i,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result_o,
    output logic                 of_o,
    output logic                 sf_o,
    output logic                 zf_o,
    output logic                 af_o,
    output logic                 pf_o,
    output logic                 cf_o
);

    ctl_state_e         state_q, state_d;
    logic [DATA_W-1:0]  core_res;
    logic               core_borrow, core_ovf, core_sign;
    flags_t             flags_d, flags_q;
    logic [DATA_W-1:0]  res_q;

    msub_core #(.W(DATA_W), .LANES(NUM_SIZES), .BASE(BYTE_W)) core_i (
        .dest_i   (dest_i),
        .src_i    (src_i),
        .size_i   (size_e'(size_sel)),
        .result_o (core_res),
        .borrow_o (core_borrow),
        .ovf_o    (core_ovf),
        .sign_o   (core_sign)
    );

    msub_flaggen #(.W(DATA_W)) flag_i (
        .result_i   (core_res),
        .dest_nib_i (dest_i[NIB_W-1:0]),
        .src_nib_i  (src_i[NIB_W-1:0]),
        .zf_o       (flags_d.zf),
        .af_o       (flags_d.af),
        .pf_o       (flags_d.pf)
    );

    assign flags_d.of = core_ovf;
    assign flags_d.sf = core_sign;
    assign flags_d.cf = core_borrow;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: capture (IDLE->EMIT), stream (EMIT->EMIT), drain (EMIT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (in_valid) begin
            res_q   <= core_res;
            flags_q <= flags_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign result_o  = res_q;
    assign of_o      = flags_q.of;
    assign sf_o      = flags_q.sf;
    assign zf_o      = flags_q.zf;
    assign af_o      = flags_q.af;
    assign pf_o      = flags_q.pf;
    assign cf_o      = flags_q.cf;

endmodule

// File: rtl/msub_flagunit_chk.sv
module msub_flagunit_chk
    import msub_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [SIZE_W-1:0]    size_sel,
    input logic [DATA_W-1:0]    dest_i,
    input logic [DATA_W-1:0]    src_i,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    result_o,
    input logic                 of_o,
    input logic                 sf_o,
    input logic                 zf_o,
    input logic                 af_o,
    input logic                 pf_o,
    input logic                 cf_o
);

    function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] s);
        logic [DATA_W-1:0] m;
        m = '1;
        return m >> (DATA_W - (BYTE_W << s));
    endfunction

    function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [SIZE_W-1:0] s);
        return v[(BYTE_W << s) - 1];
    endfunction

    // R9
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    no_strobe_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    difference_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result_o == (($past(dest_i) - $past(src_i)) & width_mask($past(size_sel)))));

    // R5
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sf_o == top_bit(result_o, $past(size_sel))));

    // R6
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zf_o == (result_o == '0)));

    // R8
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pf_o == ~(^result_o[BYTE_W-1:0])));

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result_o) && $stable(cf_o) && $stable(of_o)));

endmodule

bind msub_flagunit msub_flagunit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size_sel  (size_sel),
    .dest_i    (dest_i),
    .src_i     (src_i),
    .out_valid (out_valid),
    .result_o  (result_o),
    .of_o      (of_o),
    .sf_o      (sf_o),
    .zf_o      (zf_o),
    .af_o      (af_o),
    .pf_o      (pf_o),
    .cf_o      (cf_o)
);

// File: tb/msub_flagunit_tb_top.sv
`timescale 1ns/1ps
module msub_flagunit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [63:0] dest_i = '0;
    logic [63:0] src_i = '0;
    logic        out_valid;
    logic [63:0] result_o;
    logic        of_o, sf_o, zf_o, af_o, pf_o, cf_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msub_flagunit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .dest_i(dest_i), .src_i(src_i), .out_valid(out_valid), .result_o(result_o),
        .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .pf_o(pf_o), .cf_o(cf_o)
    );

    // Vector: {size[1:0], dest[63:0], src[63:0], result[63:0], flags {of,sf,zf,af,pf,cf}}
    localparam int NV = 11;
    localparam logic [199:0] VEC [NV] = '{
        {2'd0, 64'h0, 64'h1, 64'hFF, 6'b010111},
        {2'd0, 64'h80, 64'h1, 64'h7F, 6'b100100},
        {2'd1, 64'h8000, 64'h1, 64'h7FFF, 6'b100110},
        {2'd2, 64'h8000_0000, 64'h1, 64'h7FFF_FFFF, 6'b100110},
        {2'd3, 64'h8000_0000_0000_0000, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 6'b100110},
        {2'd2, 64'h1234_5678, 64'h1234_5678, 64'h0, 6'b001010},
        {2'd1, 64'hFFFF_FFFF_FFFF_0005, 64'hAAAA_0000_0000_0003, 64'h2, 6'b000000},
        {2'd2, 64'h0001_0300, 64'h0, 64'h0001_0300, 6'b000010},
        {2'd3, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE, 6'b010101},
        {2'd0, 64'h7F, 64'hFF, 64'h80, 6'b110001},
        {2'd0, 64'h1234_5678_9ABC_DE10, 64'h10, 64'h0, 6'b001010}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] flags_now();
        return {of_o, sf_o, zf_o, af_o, pf_o, cf_o};
    endfunction

    // Drive one strobe at a falling edge, then sample at the next falling edge.
    task automatic strobe(input logic [1:0] s, input logic [63:0] d, input logic [63:0] b);
        size_sel = s; dest_i = d; src_i = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 valid", {63'd0, out_valid}, 64'd0);
        check("R11 result", result_o, 64'd0);
        check("R11 flags", {58'd0, flags_now()}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][199:198], VEC[i][197:134], VEC[i][133:70]);
            check($sformatf("R9 valid vec%0d", i), {63'd0, out_valid}, 64'd1);
            check($sformatf("R1/R2 result vec%0d", i), result_o, VEC[i][69:6]);
            check($sformatf("R3-flags R4 R5 R6 R7 R8 vec%0d", i), {58'd0, flags_now()}, {58'd0, VEC[i][5:0]});
        end

        // 0 minus 1 at each width: R3 R5 R7 R8
        for (int s = 0; s < 4; s++) begin
            logic [63:0] m;
            m = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - (8 << s));
            strobe(2'(s), 64'h0, 64'h1);
            check($sformatf("R1 zero-minus-one size%0d", s), result_o, m);
            check($sformatf("R3 cf size%0d", s), {63'd0, cf_o}, 64'd1);
            check($sformatf("R5 sf size%0d", s), {63'd0, sf_o}, 64'd1);
            check($sformatf("R4 of size%0d", s), {63'd0, of_o}, 64'd0);
        end

        // Most negative minus 1 at each width: R4
        for (int s = 0; s < 4; s++) begin
            logic [63:0] m;
            m = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - (8 << s));
            strobe(2'(s), (m >> 1) + 64'd1, 64'h1);
            check($sformatf("R4 of min-1 size%0d", s), {63'd0, of_o}, 64'd1);
            check($sformatf("R1 min-1 size%0d", s), result_o, m >> 1);
            check($sformatf("R7 af min-1 size%0d", s), {63'd0, af_o}, 64'd1);
        end

        // R9/R10: after a strobe the valid drops and values hold while inputs move
        strobe(2'd1, 64'h0000_0000_0000_1000, 64'h1);
        check("R1 hold setup", result_o, 64'h0FFF);
        size_sel = 2'd3; dest_i = 64'hDEAD_BEEF_0000_0000; src_i = 64'h1;
        @(negedge clk);
        check("R9 valid low", {63'd0, out_valid}, 64'd0);
        check("R10 result held", result_o, 64'h0FFF);
        check("R10 flags held", {58'd0, flags_now()}, {58'd0, 6'b000110});

        // R9: back-to-back strobes
        size_sel = 2'd0; dest_i = 64'h3; src_i = 64'h1; in_valid = 1'b1;
        @(negedge clk);
        check("R9 stream first", result_o, 64'h2);
        dest_i = 64'h9; src_i = 64'h4;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 stream second", result_o, 64'h5);
        check("R9 stream valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check("R9 stream drained", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule